// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block is the event half of a power-management function. It sits in a 64-byte I/O window whose base and decode enable come from configuration values held elsewhere. Inside the window it holds an event status word, an event enable word, a control word and a read-only free-running timer. A hardware event sets its status bit whether or not it is enabled. The System Control Interrupt (SCI) is a level. It stays high while any of four sources has both its status bit and its enable bit set.

The four sources are the real-time-clock alarm, the power button, the global-lock release and the timer carry. The carry is the moment the timer's most significant bit changes state. Software clears status bits by writing ones to them, and it chooses which sources may interrupt through the enable word.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status, enable and control words and the timer are all zero, and `sci` is low.
- R2: An access decodes (`io_hit` high) when `io_addr[15:6]` equals `cfg_base[15:6]`. Bits 31:16 and 5:0 of `cfg_base` are ignored, so the window is 64 bytes long and 64-byte aligned.
- R3: When `cfg_misc[0]` is 0, `io_hit` stays low, and writes anywhere change no register.
- R4: The window holds these registers: status at offset 0x00, enable at 0x02, control at 0x04 and timer at 0x08. `io_rdata` takes the addressed value at the clock edge on which `io_rd` is sampled with a hit. Unmapped offsets read zero. Only bits 0, 5, 8 and 10 of the status and enable words are implemented, and the other bits read zero.
- R5: A status bit clears when a one is written to it. Writing zero leaves the bit unchanged. A hardware event in the same cycle as a clear of its bit wins, so the bit stays set.
- R6: The inputs set status bits on their rising edges, whatever the enable word holds: the timer carry sets bit 0, `ev_glbl` sets bit 5, `ev_pwrbtn` sets bit 8 and `ev_rtc` sets bit 10. An input held high does not set its bit again after the bit is cleared.
- R7: `sci` is high exactly while (status AND enable) has bit 0, 5, 8 or 10 set. It follows a status or enable change on the same edge that updates the register.
- R8: The timer is a `TMR_W`-bit up-counter. It advances once per clock while `tick_en` is high, wraps to zero, and ignores writes.
- R9: Each change of the timer's most significant bit sets status bit 0. This happens on the rise at half range and on the wrap to zero.
- R10: The control word is a plain 16-bit read/write register and has no effect on `sci`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Configuration dword holding the window base |
| cfg_misc | input | 8 | Configuration byte; bit 0 enables window decode |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Registered read data |
| io_hit | output | 1 | Address falls inside the enabled window |
| tick_en | input | 1 | Timer advance enable |
| ev_rtc | input | 1 | Real-time-clock alarm event |
| ev_pwrbtn | input | 1 | Power button event |
| ev_glbl | input | 1 | Global lock release event |
| sci | output | 1 | Level-sensitive SCI |

## Verification
`io_hit` is combinational and is sampled a moment after the address settles. Writes, event edges and timer ticks reach the registers on the next rising edge, and `sci` follows from those registers without another stage. `io_rdata` is loaded on the edge that samples `io_rd`. The bench drives every input on the falling edge and samples each result on the following falling edge, which is one register stage after the stimulus. A status bit set by the timer carry is checked only after the exact number of ticking cycles that reaches the toggle.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    // status/enable bit positions (shared by decode, status logic and bench)
    localparam int TMR_BIT    = 0;
    localparam int GLBL_BIT   = 5;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    localparam logic [15:0] EVT_MASK = 16'h0521;

    // byte offsets inside the window
    localparam int OFS_STS = 'h00;
    localparam int OFS_EN  = 'h02;
    localparam int OFS_CTL = 'h04;
    localparam int OFS_TMR = 'h08;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL,
        SEL_TMR
    } reg_sel_e;

    typedef struct packed {
        logic [15:0] sts;
        logic [15:0] en;
        logic [15:0] ctl;
        logic [2:0]  ev_prev;   // {rtc, pwrbtn, glbl}
    } evt_state_t;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              win_en,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] BASE_MASK =
        {{(ADDR_W-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};

    logic [WIN_BITS-1:0] offs;

    always_comb begin
        offs = io_addr[WIN_BITS-1:0];
        hit  = win_en && ((io_addr & BASE_MASK) == (base & BASE_MASK));
        sel  = SEL_NONE;
        if (hit) begin
            case (int'(offs))
                OFS_STS: sel = SEL_STS;
                OFS_EN:  sel = SEL_EN;
                OFS_CTL: sel = SEL_CTL;
                OFS_TMR: sel = SEL_TMR;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] cnt,
    output logic             msb_flip
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = tick_en ? cnt_q + TMR_W'(1) : cnt_q;
        msb_flip = cnt_d[MSB] ^ cnt_q[MSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_tmr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));
    assert_tmr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt_q == $past(cnt_q) + TMR_W'(1)));
    assert_msb_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[MSB] != $past(cnt_q[MSB])) |-> $past(msb_flip));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sts,
    input  logic        wr_en,
    input  logic        wr_ctl,
    input  logic [15:0] wdata,
    input  logic [2:0]  ext_ev,     // {rtc, pwrbtn, glbl}
    input  logic        tmr_flip,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic [15:0] ctl,
    output logic        sci
);
    evt_state_t  st_d, st_q;
    logic [2:0]  rise;
    logic [15:0] set_vec;

    always_comb begin
        rise                = ext_ev & ~st_q.ev_prev;
        set_vec             = '0;
        set_vec[TMR_BIT]    = tmr_flip;
        set_vec[GLBL_BIT]   = rise[0];
        set_vec[PWRBTN_BIT] = rise[1];
        set_vec[RTC_BIT]    = rise[2];

        st_d         = st_q;
        st_d.ev_prev = ext_ev;
        if (wr_sts) st_d.sts = st_q.sts & ~wdata;
        st_d.sts = (st_d.sts | set_vec) & EVT_MASK;
        if (wr_en)  st_d.en  = wdata & EVT_MASK;
        if (wr_ctl) st_d.ctl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign ctl = st_q.ctl;
    assign sci = |(st_q.sts & st_q.en & EVT_MASK);

    assert_sts_only_by_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((st_q.sts & ~$past(st_q.sts)) == '0));
    assert_sci_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci) |-> $past(wr_sts || wr_en || (set_vec != '0)));
    assert_ctl_no_sci_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wr_sts && !wr_en && set_vec == '0) |=> $stable(sci));
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6,
    parameter int TMR_W    = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_base,
    input  logic [7:0]  cfg_misc,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [15:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_hit,
    input  logic        tick_en,
    input  logic        ev_rtc,
    input  logic        ev_pwrbtn,
    input  logic        ev_glbl,
    output logic        sci
);
    reg_sel_e         sel;
    logic [15:0]      sts_v, en_v, ctl_v;
    logic [TMR_W-1:0] tmr_v;
    logic             tmr_flip;
    logic [31:0]      rdata_d, rdata_q, rmux;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_base[31:ADDR_W], cfg_base[WIN_BITS-1:0], cfg_misc[7:1]};

    pm_win_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .io_addr (io_addr[ADDR_W-1:0]),
        .base    (cfg_base[ADDR_W-1:0]),
        .win_en  (cfg_misc[0]),
        .hit     (io_hit),
        .sel     (sel)
    );

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt      (tmr_v),
        .msb_flip (tmr_flip)
    );

    pm_evt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sts   (io_wr && sel == SEL_STS),
        .wr_en    (io_wr && sel == SEL_EN),
        .wr_ctl   (io_wr && sel == SEL_CTL),
        .wdata    (io_wdata),
        .ext_ev   ({ev_rtc, ev_pwrbtn, ev_glbl}),
        .tmr_flip (tmr_flip),
        .sts      (sts_v),
        .en       (en_v),
        .ctl      (ctl_v),
        .sci      (sci)
    );

    always_comb begin
        case (sel)
            SEL_STS: rmux = {16'h0, sts_v};
            SEL_EN:  rmux = {16'h0, en_v};
            SEL_CTL: rmux = {16'h0, ctl_v};
            SEL_TMR: rmux = 32'(tmr_v);
            default: rmux = '0;
        endcase
        rdata_d = (io_rd && io_hit) ? rmux : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign io_rdata = rdata_q;

    assert_win_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_hit) |=> ($stable(en_v) && $stable(ctl_v)));
    assert_no_hit_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_misc[0] |-> !io_hit);
endmodule

// File: tb/pm_event_sci_tb.sv
module pm_event_sci_tb_top;
    localparam int TW = 8;
    localparam logic [15:0] WBASE = 16'h4C00;

    logic        clk = 0, rst_n = 0;
    logic [31:0] cfg_base = 32'hFFFF_4C3F;
    logic [7:0]  cfg_misc = 8'h01;
    logic [15:0] io_addr = 0, io_wdata = 0;
    logic        io_wr = 0, io_rd = 0, tick_en = 0;
    logic        ev_rtc = 0, ev_pwrbtn = 0, ev_glbl = 0;
    logic [31:0] io_rdata;
    logic        io_hit, sci;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pm_event_sci #(.TMR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_misc(cfg_misc),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit), .tick_en(tick_en),
        .ev_rtc(ev_rtc), .ev_pwrbtn(ev_pwrbtn), .ev_glbl(ev_glbl), .sci(sci)
    );

    // {op[1:0] (1=write, 2=read), offset[7:0], data[15:0], expected[31:0]}
    localparam int NV = 13;
    localparam logic [57:0] VEC [0:NV-1] = '{
        {2'd1, 8'h02, 16'hFFFF, 32'h0},
        {2'd2, 8'h02, 16'h0000, 32'h0000_0521},
        {2'd1, 8'h04, 16'hABCD, 32'h0},
        {2'd2, 8'h04, 16'h0000, 32'h0000_ABCD},
        {2'd2, 8'h06, 16'h0000, 32'h0},
        {2'd1, 8'h08, 16'h1234, 32'h0},
        {2'd2, 8'h08, 16'h0000, 32'h0},
        {2'd2, 8'h00, 16'h0000, 32'h0},
        {2'd1, 8'h02, 16'h0000, 32'h0},
        {2'd2, 8'h02, 16'h0000, 32'h0},
        {2'd1, 8'h00, 16'hFFFF, 32'h0},
        {2'd2, 8'h00, 16'h0000, 32'h0},
        {2'd2, 8'h0A, 16'h0000, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] ofs, input logic [15:0] d);
        @(negedge clk);
        io_addr = WBASE + 16'(ofs); io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic io_read(input logic [7:0] ofs, output logic [31:0] d);
        @(negedge clk);
        io_addr = WBASE + 16'(ofs); io_rd = 1;
        @(negedge clk);
        io_rd = 0;
        d = io_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        // R1: reset values
        do_reset();
        check("R1 sci", {31'b0, sci}, 0);
        io_read(8'h00, rd); check("R1 status", rd, 0);
        io_read(8'h02, rd); check("R1 enable", rd, 0);
        io_read(8'h04, rd); check("R1 control", rd, 0);
        io_read(8'h08, rd); check("R1 timer", rd, 0);

        // R3: window disabled -> no hit, writes ignored
        cfg_misc = 8'hFE;
        @(negedge clk); io_addr = WBASE + 16'h2; #1;
        check("R3 hit off", {31'b0, io_hit}, 0);
        io_write(8'h02, 16'hFFFF);
        io_write(8'h04, 16'h5555);
        cfg_misc = 8'h01;
        io_read(8'h02, rd); check("R3 enable untouched", rd, 0);
        io_read(8'h04, rd); check("R3 control untouched", rd, 0);

        // R4 R10 R8: table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][57:56] == 2'd1) io_write(VEC[i][55:48], VEC[i][47:32]);
            else begin
                io_read(VEC[i][55:48], rd);
                check($sformatf("R4 R10 R8 table %0d", i), rd, VEC[i][31:0]);
            end
        end

        // R2: base decode
        cfg_base = 32'h1234_B041;
        @(negedge clk); io_addr = 16'hB040; #1; check("R2 low edge", {31'b0, io_hit}, 1);
        @(negedge clk); io_addr = 16'hB07F; #1; check("R2 high edge", {31'b0, io_hit}, 1);
        @(negedge clk); io_addr = 16'hB080; #1; check("R2 above", {31'b0, io_hit}, 0);
        @(negedge clk); io_addr = 16'hB03F; #1; check("R2 below", {31'b0, io_hit}, 0);
        cfg_base = 32'hFFFF_4C3F;

        // R6 R7: event sets status with enable off, no sci
        do_reset();
        @(negedge clk); ev_pwrbtn = 1;
        @(negedge clk); ev_pwrbtn = 0;
        check("R6 R7 sci masked", {31'b0, sci}, 0);
        io_read(8'h00, rd); check("R6 pwrbtn bit 8", rd, 32'h0100);
        io_write(8'h02, 16'h0100);
        check("R7 sci on enable", {31'b0, sci}, 1);
        io_write(8'h00, 16'h0000);
        io_read(8'h00, rd); check("R5 write zero keeps", rd, 32'h0100);
        io_write(8'h00, 16'h0100);
        check("R5 R7 sci after clear", {31'b0, sci}, 0);
        io_read(8'h00, rd); check("R5 cleared", rd, 0);

        // R5: event beats same-cycle clear; R6 held level no re-set
        @(negedge clk);
        io_addr = WBASE; io_wdata = 16'h0400; io_wr = 1; ev_rtc = 1;
        @(negedge clk); io_wr = 0;
        io_read(8'h00, rd); check("R5 event wins clear", rd, 32'h0400);
        io_write(8'h00, 16'h0400);
        repeat (3) @(negedge clk);
        io_read(8'h00, rd); check("R6 held level no reset", rd, 0);
        ev_rtc = 0;

        // R10: control has no effect on sci; R6 glbl bit 5
        @(negedge clk); ev_glbl = 1;
        @(negedge clk); ev_glbl = 0;
        io_read(8'h00, rd); check("R6 glbl bit 5", rd, 32'h0020);
        io_write(8'h02, 16'h0000);
        io_write(8'h04, 16'hFFFF);
        check("R10 control no sci", {31'b0, sci}, 0);
        io_write(8'h02, 16'h0020);
        check("R7 glbl sci", {31'b0, sci}, 1);

        // R8 R9: timer
        do_reset();
        ticks(5);
        io_read(8'h08, rd); check("R8 count", rd, 5);
        io_read(8'h00, rd); check("R9 no carry yet", rd, 0);
        ticks(123);
        io_read(8'h08, rd); check("R8 half range", rd, 32'h80);
        io_read(8'h00, rd); check("R9 msb rise", rd, 32'h0001);
        io_write(8'h02, 16'h0001);
        check("R7 timer sci", {31'b0, sci}, 1);
        io_write(8'h00, 16'h0001);
        check("R7 timer sci clear", {31'b0, sci}, 0);
        ticks(128);
        io_read(8'h08, rd); check("R8 wrap", rd, 0);
        io_read(8'h00, rd); check("R9 msb fall", rd, 32'h0001);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule